// File: doc/BRIEF.md
# Word-to-byte bus data multiplexer

This block connects a 16-bit word-addressed processor bus to an 8-bit byte-addressed peripheral bus. A word access aimed at slow space becomes two byte transfers in a fixed order. For a read, the odd byte is fetched first and becomes the low half of the word, then the even byte is fetched and becomes the high half. For a write, the low half of the data goes to the odd byte first and the high half to the even byte. While the pair of transfers is in flight, the processor-side `ready` output is held low.

The block also contains a fast 16-bit word RAM that answers two address windows while `ram_en` is set. The low window covers byte addresses 0x2000–0x3FFF. The high window covers byte addresses 0xA000–0xFFFF. An access in either window finishes as one word access on the next cycle, and no wait state is inserted. The low window indexes the RAM with the word address less 0x1000, and the high window uses the word address less 0x4000. The result is taken modulo the RAM depth of 2^RAM_AW words.

Top module: `word_byte_mux`

## Requirements
- R1: A split access drives byte address {word address, 1} on the byte bus first and byte address {word address, 0} second. The byte address is the word address shifted left by one bit.
- R2: With `ram_en` high, a word whose byte address has top three bits 001 (0x2000–0x3FFF) goes to the internal RAM. It causes no byte-bus transfer.
- R3: With `ram_en` high, byte addresses 0xA000–0xBFFF (top bits 101) and 0xC000–0xFFFF (top bits 11) go to the internal RAM. Byte addresses 0x1FFE and 0x9FFE stay on the byte bus.
- R4: The RAM index is (word address − 0x1000) for the low window and (word address − 0x4000) for the high window, both modulo 2^RAM_AW. Word 0x1003 and word 0x5003 therefore share one location.
- R5: With `ram_en` low, every address, window addresses included, is served by two byte transfers.
- R6: A split read returns `rdata` = {byte read from the even address, byte read from the odd address}.
- R7: A split write puts `wdata[7:0]` on the odd address first and then `wdata[15:8]` on the even address, with `bus_we` high on both transfers.
- R8: After a split request is accepted, `ready` is low from the next cycle. It stays low until the cycle after the second `bus_ack`, where `ready` returns high and `resp_valid` pulses for one cycle.
- R9: A RAM access returns `resp_valid` on the cycle after acceptance, with `ready` still high. A read delivers the word last written to that location.
- R10: While `bus_req` is high and `bus_ack` is low, `bus_addr`, `bus_we` and `bus_wdata` hold their values. One byte transfer completes in each cycle in which `bus_req` and `bus_ack` are both high.
- R11: A request presented while `ready` is low is ignored. It starts no byte transfer and produces no response.
- R12: Synchronous active-high reset returns the block to idle with `ready` high, `bus_req` low and `resp_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_en | input | 1 | Enables the internal RAM windows |
| req_valid | input | 1 | Word request, taken when `ready` is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_waddr | input | BYTE_AW-1 | Word address |
| req_wdata | input | 16 | Write word |
| ready | output | 1 | High when a request can be accepted |
| resp_valid | output | 1 | One-cycle pulse when an access completes |
| rdata | output | 16 | Read word, valid with `resp_valid` |
| bus_req | output | 1 | Byte transfer request |
| bus_we | output | 1 | Byte transfer is a write |
| bus_addr | output | BYTE_AW | Byte address |
| bus_wdata | output | 8 | Byte write data |
| bus_ack | input | 1 | Downstream completes the current byte |
| bus_rdata | input | 8 | Byte read data, valid with `bus_ack` |

## Verification
The assertions assume that the downstream side raises `bus_ack` only while `bus_req` is high. They also assume that `bus_ack` stays high for exactly one cycle per transfer, so that a second transfer is never credited to the first. The downstream model in the bench follows both rules, and it stretches the wait before each acknowledge by a programmable delay. The processor side asserts `req_valid` for a single cycle while `ready` is high, except in the scenario that deliberately issues a request while the block is busy.

// File: rtl/wbm_pkg.sv
package wbm_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ODD  = 2'd1,
    SEQ_EVEN = 2'd2
  } seq_state_e;
endpackage

// File: rtl/wbm_window_decode.sv
module wbm_window_decode #(
  parameter int BYTE_AW   = 16,
  parameter int RAM_AW    = 11,
  parameter int LOW_BASE  = 'h1000,
  parameter int HIGH_BASE = 'h4000
) (
  input  logic               ram_en,
  input  logic [BYTE_AW-2:0] waddr,
  output logic               hit,
  output logic [RAM_AW-1:0]  index
);
  localparam int WORD_AW = BYTE_AW - 1;

  logic [BYTE_AW-1:0] byte_addr;
  logic [2:0]         top3;
  logic               low_hit, high_hit;
  logic [WORD_AW-1:0] base_sel, diff;

  always_comb begin
    byte_addr = {waddr, 1'b0};
    top3      = byte_addr[BYTE_AW-1 -: 3];
    low_hit   = (top3 == 3'b001);
    high_hit  = (top3 == 3'b101) || (top3[2:1] == 2'b11);
    hit       = ram_en && (low_hit || high_hit);
    base_sel  = low_hit ? WORD_AW'(LOW_BASE) : WORD_AW'(HIGH_BASE);
    diff      = waddr - base_sel;
    index     = diff[RAM_AW-1:0];
  end
endmodule

// File: rtl/wbm_word_ram.sv
module wbm_word_ram #(
  parameter int AW = 11,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/wbm_byte_seq.sv
module wbm_byte_seq
  import wbm_pkg::*;
#(
  parameter int BYTE_AW = 16,
  parameter int BW      = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               start_we,
  input  logic [BYTE_AW-2:0] start_waddr,
  input  logic [2*BW-1:0]    start_wdata,
  output logic               idle,
  output logic               done,
  output logic [2*BW-1:0]    word_out,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BYTE_AW-1:0] bus_addr,
  output logic [BW-1:0]      bus_wdata,
  input  logic               bus_ack,
  input  logic [BW-1:0]      bus_rdata
);
  seq_state_e         state;
  logic               req_q, we_q, done_q;
  logic [BYTE_AW-1:0] addr_q;
  logic [BW-1:0]      wbyte_q, hi_keep_q, lo_q;
  logic [2*BW-1:0]    word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= SEQ_IDLE;
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        SEQ_IDLE: if (start) begin
          state <= SEQ_ODD;
          req_q <= 1'b1;
        end
        SEQ_ODD: if (bus_ack) state <= SEQ_EVEN;
        SEQ_EVEN: if (bus_ack) begin
          state  <= SEQ_IDLE;
          req_q  <= 1'b0;
          done_q <= 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == SEQ_IDLE && start) begin
      addr_q    <= {start_waddr, 1'b1};
      we_q      <= start_we;
      wbyte_q   <= start_wdata[BW-1:0];
      hi_keep_q <= start_wdata[2*BW-1:BW];
    end else if (state == SEQ_ODD && bus_ack) begin
      lo_q      <= bus_rdata;
      addr_q[0] <= 1'b0;
      wbyte_q   <= hi_keep_q;
    end else if (state == SEQ_EVEN && bus_ack) begin
      word_q    <= {bus_rdata, lo_q};
    end
  end

  assign idle      = (state == SEQ_IDLE);
  assign done      = done_q;
  assign word_out  = word_q;
  assign bus_req   = req_q;
  assign bus_we    = we_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = wbyte_q;

  // R10: request, address and data hold until acknowledged
  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  // R1: the first transfer of a pair uses the odd byte address
  assert_odd_first_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> bus_addr[0]);

  // R1: an acknowledged odd transfer is followed by the even byte of the same word
  assert_even_follows_R1: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && bus_addr[0] |=> bus_req && !bus_addr[0] &&
      bus_addr[BYTE_AW-1:1] == $past(bus_addr[BYTE_AW-1:1]));

  // R7: the even-byte write carries the high half captured at the start
  assert_even_write_data_R7: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && bus_addr[0] && bus_we |=> bus_wdata == $past(hi_keep_q));
endmodule

// File: rtl/word_byte_mux.sv
module word_byte_mux #(
  parameter int BYTE_AW   = 16,
  parameter int RAM_AW    = 11,
  parameter int LOW_BASE  = 'h1000,
  parameter int HIGH_BASE = 'h4000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ram_en,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [BYTE_AW-2:0] req_waddr,
  input  logic [15:0]        req_wdata,
  output logic               ready,
  output logic               resp_valid,
  output logic [15:0]        rdata,
  output logic               bus_req,
  output logic               bus_we,
  output logic [BYTE_AW-1:0] bus_addr,
  output logic [7:0]         bus_wdata,
  input  logic               bus_ack,
  input  logic [7:0]         bus_rdata
);
  localparam int BW = 8;
  localparam int DW = 2 * BW;

  logic              ram_hit;
  logic [RAM_AW-1:0] ram_index;
  logic              accept, ram_go, split_go;
  logic              seq_idle, seq_done;
  logic [DW-1:0]     seq_word, ram_rdata;
  logic              ram_resp_q, ram_sel_q;

  wbm_window_decode #(
    .BYTE_AW(BYTE_AW), .RAM_AW(RAM_AW), .LOW_BASE(LOW_BASE), .HIGH_BASE(HIGH_BASE)
  ) u_decode (
    .ram_en(ram_en), .waddr(req_waddr), .hit(ram_hit), .index(ram_index)
  );

  assign accept   = req_valid && seq_idle;
  assign ram_go   = accept && ram_hit;
  assign split_go = accept && !ram_hit;

  wbm_word_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_go && req_we), .re(ram_go && !req_we),
    .addr(ram_index), .wdata(req_wdata), .rdata(ram_rdata)
  );

  wbm_byte_seq #(.BYTE_AW(BYTE_AW), .BW(BW)) u_seq (
    .clk(clk), .rst(rst), .start(split_go), .start_we(req_we),
    .start_waddr(req_waddr), .start_wdata(req_wdata),
    .idle(seq_idle), .done(seq_done), .word_out(seq_word),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_resp_q <= 1'b0;
      ram_sel_q  <= 1'b0;
    end else begin
      ram_resp_q <= ram_go;
      if (ram_go)        ram_sel_q <= 1'b1;
      else if (split_go) ram_sel_q <= 1'b0;
    end
  end

  assign ready      = seq_idle;
  assign resp_valid = ram_resp_q || seq_done;
  assign rdata      = ram_sel_q ? ram_rdata : seq_word;

  // R9: an internal RAM access answers on the next cycle without a wait state
  assert_ram_no_wait_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid && ready && ram_hit |=> resp_valid && ready && !bus_req);

  // R8: a split request drops ready and starts the byte bus on the next cycle
  assert_split_holds_ready_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid && ready && !ram_hit |=> !ready && bus_req);

  // R8: ready stays low while any byte transfer is outstanding
  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> !ready);

  // R8: a split completion coincides with ready returning
  assert_done_ready_R8: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack && !bus_addr[0] |=> resp_valid && ready && !bus_req);

  // R12: reset leaves the block idle
  assert_reset_idle_R12: assert property (@(posedge clk)
    rst |=> ready && !bus_req && !resp_valid);
endmodule

// File: tb/word_byte_mux_tb.sv
module word_byte_mux_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ram_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [14:0] req_waddr = '0;
  logic [15:0] req_wdata = '0;
  logic        ready, resp_valid;
  logic [15:0] rdata;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_ack = 1'b0;
  logic [7:0]  bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lat = 0;
  int wait_cnt = 0;
  int log_n = 0;
  logic log_clr = 1'b0;
  logic [15:0] log_addr [16];
  logic        log_we   [16];
  logic [7:0]  log_data [16];

  always #5 clk = ~clk;

  word_byte_mux dut_i (
    .clk(clk), .rst(rst), .ram_en(ram_en), .req_valid(req_valid), .req_we(req_we),
    .req_waddr(req_waddr), .req_wdata(req_wdata), .ready(ready), .resp_valid(resp_valid),
    .rdata(rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  // Downstream byte-bus model with a programmable wait before each acknowledge
  always @(posedge clk) begin
    if (log_clr) log_n = 0;
    if (bus_ack) begin
      bus_ack <= 1'b0;
      wait_cnt = 0;
    end else if (bus_req) begin
      if (wait_cnt >= lat) begin
        bus_ack   <= 1'b1;
        bus_rdata <= pat(bus_addr);
        if (log_n < 16) begin
          log_addr[log_n] = bus_addr;
          log_we[log_n]   = bus_we;
          log_data[log_n] = bus_wdata;
        end
        log_n = log_n + 1;
        wait_cnt = 0;
      end else begin
        wait_cnt = wait_cnt + 1;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual run length %0d expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  // Issues one request and waits for its response; returns read word and busy-cycle count
  task automatic access(input logic we, input logic [14:0] wa, input logic [15:0] wd,
                        output logic [15:0] rd, output int busy, output logic ready_at_resp);
    int n;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_waddr = wa; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 0;
    n = 0;
    while (!resp_valid && n < 200) begin
      if (!ready) busy = busy + 1;
      @(negedge clk);
      n = n + 1;
    end
    rd = rdata;
    ready_at_resp = ready;
    if (n >= 200) chk("R8 response timeout", 32'd0, 32'd1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R12 ready after reset", ready, 1);
    chk("R12 bus_req after reset", bus_req, 0);
    chk("R12 resp_valid after reset", resp_valid, 0);
  endtask

  task automatic t_split_read(input int l, input logic [14:0] wa);
    logic [15:0] rd; int busy; logic rdy;
    lat = l; ram_en = 1'b1;
    clear_log();
    access(1'b0, wa, 16'h0, rd, busy, rdy);
    chk("R6 split read word", rd, {pat({wa, 1'b0}), pat({wa, 1'b1})});
    chk("R1 transfer count", log_n, 2);
    chk("R1 odd address first", log_addr[0], {wa, 1'b1});
    chk("R1 even address second", log_addr[1], {wa, 1'b0});
    chk("R10 read transfers not writes", {log_we[0], log_we[1]}, 2'b00);
    chk("R8 ready low during split", busy, 2 * (l + 2));
    chk("R8 ready back with response", rdy, 1);
  endtask

  task automatic t_split_write();
    logic [15:0] rd; int busy; logic rdy;
    lat = 2; ram_en = 1'b1;
    clear_log();
    access(1'b1, 15'h0234, 16'hBEEF, rd, busy, rdy);
    chk("R7 write transfer count", log_n, 2);
    chk("R7 odd address first", log_addr[0], 16'h0469);
    chk("R7 low byte to odd", log_data[0], 8'hEF);
    chk("R7 even address second", log_addr[1], 16'h0468);
    chk("R7 high byte to even", log_data[1], 8'hBE);
    chk("R7 both are writes", {log_we[0], log_we[1]}, 2'b11);
  endtask

  task automatic t_ram_low();
    logic [15:0] rd; int busy; logic rdy;
    ram_en = 1'b1; lat = 0;
    clear_log();
    access(1'b1, 15'h1003, 16'hA55A, rd, busy, rdy);
    chk("R9 RAM write no wait", busy, 0);
    access(1'b0, 15'h1003, 16'h0, rd, busy, rdy);
    chk("R9 RAM read back", rd, 16'hA55A);
    chk("R9 RAM read no wait", busy, 0);
    chk("R2 low window uses no byte bus", log_n, 0);
  endtask

  task automatic t_ram_high_alias();
    logic [15:0] rd; int busy; logic rdy;
    ram_en = 1'b1;
    clear_log();
    access(1'b0, 15'h5003, 16'h0, rd, busy, rdy);
    chk("R4 high window shares index with low", rd, 16'hA55A);
    access(1'b1, 15'h6010, 16'h1234, rd, busy, rdy);
    access(1'b1, 15'h7FFF, 16'h4321, rd, busy, rdy);
    access(1'b0, 15'h6010, 16'h0, rd, busy, rdy);
    chk("R3 0xC020 served by RAM", rd, 16'h1234);
    access(1'b0, 15'h7FFF, 16'h0, rd, busy, rdy);
    chk("R3 0xFFFE served by RAM", rd, 16'h4321);
    chk("R3 high windows use no byte bus", log_n, 0);
  endtask

  task automatic t_edges();
    logic [15:0] rd; int busy; logic rdy;
    ram_en = 1'b1; lat = 0;
    clear_log();
    access(1'b0, 15'h0FFF, 16'h0, rd, busy, rdy);
    chk("R3 0x1FFE stays on byte bus", log_n, 2);
    access(1'b0, 15'h4FFF, 16'h0, rd, busy, rdy);
    chk("R3 0x9FFE stays on byte bus", log_n, 4);
    chk("R6 0x9FFE word", rd, {pat(16'h9FFE), pat(16'h9FFF)});
  endtask

  task automatic t_ram_disabled();
    logic [15:0] rd; int busy; logic rdy;
    ram_en = 1'b0; lat = 1;
    clear_log();
    access(1'b0, 15'h1003, 16'h0, rd, busy, rdy);
    chk("R5 window goes to byte bus when disabled", log_n, 2);
    chk("R5 word from byte bus", rd, {pat(16'h2006), pat(16'h2007)});
    access(1'b1, 15'h5003, 16'h7788, rd, busy, rdy);
    chk("R5 write goes to byte bus when disabled", log_n, 4);
    ram_en = 1'b1;
    access(1'b0, 15'h1003, 16'h0, rd, busy, rdy);
    chk("R5 RAM untouched while disabled", rd, 16'hA55A);
  endtask

  task automatic t_ignore_busy();
    int resp_n;
    ram_en = 1'b1; lat = 3;
    clear_log();
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_waddr = 15'h0100;
    @(negedge clk);
    req_waddr = 15'h0200;
    req_we = 1'b1;
    resp_n = 0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (resp_valid) resp_n = resp_n + 1;
      @(negedge clk);
    end
    chk("R11 busy request starts no transfer", log_n, 2);
    chk("R11 only one response", resp_n, 1);
    chk("R11 bus idle afterwards", bus_req, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_split_read(0, 15'h0123);
    t_split_read(3, 15'h4ABC);
    t_split_write();
    t_ram_low();
    t_ram_high_alias();
    t_edges();
    t_ram_disabled();
    t_ignore_busy();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
    finish_run();
  end
endmodule